// File: doc/BRIEF.md
# Vector Lane Move Unit

This unit carries data in both directions between a 32-bit scalar register value and a 128-bit vector value. A fill request broadcasts the low part of the scalar into every lane of a vector. A copy request extracts one indexed lane of the vector as a 32-bit scalar. The copy can sign-extend or zero-extend that lane. Each request selects its own lane size: byte, halfword or word.

The caller presents one request per cycle with a valid strobe. One clock later the unit returns a registered result with a valid pulse, or it raises an error pulse if the request cannot be served. The vector result and the scalar result have separate output buses. The bus that the operation does not use is driven to zero.

Top module: `lane_move_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `res_valid`, `res_err`, `res_vec` and `res_scalar` are all cleared to zero.
- R2: Operation codes on `req_op` are 0 = fill, 1 = copy-signed, 2 = copy-unsigned and 3 = reserved. Format codes on `req_fmt` are 0 = byte (16 lanes), 1 = halfword (8 lanes), 2 = word (4 lanes) and 3 = doubleword. Lane k sits at bits [k*w+w-1 : k*w] of the vector, where w is the lane width.
- R3: Fill writes the low w bits of `req_scalar` into every lane of `res_vec` and drives `res_scalar` to zero.
- R4: Copy-signed with byte or halfword format returns the selected lane sign-extended to 32 bits on `res_scalar`, and drives `res_vec` to zero.
- R5: Copy-unsigned with byte or halfword format returns the selected lane zero-extended to 32 bits on `res_scalar`.
- R6: With word format, both copy operations return the selected 32-bit lane unchanged.
- R7: A copy whose index is not below the lane count (8 for halfword, 4 for word) is rejected. Fill ignores the index.
- R8: A rejected request produces a single `res_err` pulse in the next cycle and no `res_valid`, and leaves `res_vec` and `res_scalar` unchanged. Requests with format 3 or operation 3 are rejected, and so are out-of-range copies.
- R9: An accepted request produces exactly one `res_valid` pulse, one clock after it is presented. A cycle with no request leaves both `res_valid` and `res_err` low in the next cycle.
- R10: `res_valid` and `res_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code |
| req_fmt | input | 2 | Lane size code |
| req_idx | input | 4 | Lane index for copy |
| req_scalar | input | 32 | Scalar source for fill |
| req_vec | input | 128 | Vector source for copy |
| res_valid | output | 1 | Result valid pulse |
| res_err | output | 1 | Rejected request pulse |
| res_vec | output | 128 | Vector result of fill |
| res_scalar | output | 32 | Scalar result of copy |

## Verification
The assertions check the following on every cycle:
- the one-cycle latency of valid and error;
- that valid and error are mutually exclusive;
- that outputs hold after a rejection;
- byte-fill replication;
- the upper bits of byte zero-extension and halfword sign-extension.

Only the bench scenarios can show the remaining behaviour:
- that the correct lane is picked for each index and lane size;
- the word-format pass-through;
- that fill ignores the index;
- the exact reset values.

// File: rtl/lmv_pkg.sv
// Package: shared operation and format codes for the lane move unit.
// Assumes two-bit encodings for both fields, as in the brief.
package lmv_pkg;
    typedef enum logic [1:0] {
        OP_FILL   = 2'd0,
        OP_COPY_S = 2'd1,
        OP_COPY_U = 2'd2,
        OP_RSVD   = 2'd3
    } lmv_op_e;

    typedef enum logic [1:0] {
        FMT_B = 2'd0,
        FMT_H = 2'd1,
        FMT_W = 2'd2,
        FMT_D = 2'd3
    } lmv_fmt_e;
endpackage

// File: rtl/lmv_decode.sv
// Module: lmv_decode
// Classifies a request as legal or not and flags fills.
// Assumes VEC_W is a multiple of 32 and IDX_W covers the byte lane count.
module lmv_decode #(
    parameter int VEC_W = 128,
    parameter int IDX_W = 4
) (
    input  logic [1:0]       op,
    input  logic [1:0]       fmt,
    input  logic [IDX_W-1:0] idx,
    output logic             legal,
    output logic             is_fill
);
    import lmv_pkg::*;
    localparam int LANES_B = VEC_W / 8;
    localparam int LANES_H = VEC_W / 16;
    localparam int LANES_W = VEC_W / 32;

    logic idx_ok;

    // Range check of the lane index against the lane count of the format
    always_comb begin
        case (lmv_fmt_e'(fmt))
            FMT_B:   idx_ok = ({1'b0, idx} < (IDX_W+1)'(LANES_B));
            FMT_H:   idx_ok = ({1'b0, idx} < (IDX_W+1)'(LANES_H));
            FMT_W:   idx_ok = ({1'b0, idx} < (IDX_W+1)'(LANES_W));
            default: idx_ok = 1'b0;
        endcase
    end

    // Legality: reserved op and doubleword format always fail; fills skip the index check
    always_comb begin
        is_fill = (lmv_op_e'(op) == OP_FILL);
        legal   = (lmv_op_e'(op) != OP_RSVD) && (lmv_fmt_e'(fmt) != FMT_D)
                  && (is_fill || idx_ok);
    end
endmodule

// File: rtl/lmv_fill.sv
// Module: lmv_fill
// Broadcasts the low part of a scalar into every lane at the chosen size.
// Assumes the format has already been checked; doubleword gives zero.
module lmv_fill #(
    parameter int VEC_W = 128,
    parameter int SCL_W = 32
) (
    input  logic [1:0]       fmt,
    input  logic [SCL_W-1:0] scalar,
    output logic [VEC_W-1:0] vec
);
    import lmv_pkg::*;
    localparam int LANES_B = VEC_W / 8;
    localparam int LANES_H = VEC_W / 16;
    localparam int LANES_W = VEC_W / 32;

    logic [VEC_W-1:0] rep_b, rep_h, rep_w;

    genvar gi;
    generate
        for (gi = 0; gi < LANES_B; gi++) begin : g_b
            assign rep_b[gi*8 +: 8] = scalar[7:0];
        end
        for (gi = 0; gi < LANES_H; gi++) begin : g_h
            assign rep_h[gi*16 +: 16] = scalar[15:0];
        end
        for (gi = 0; gi < LANES_W; gi++) begin : g_w
            assign rep_w[gi*32 +: 32] = scalar[31:0];
        end
    endgenerate

    // Choose the replication matching the lane size
    always_comb begin
        case (lmv_fmt_e'(fmt))
            FMT_B:   vec = rep_b;
            FMT_H:   vec = rep_h;
            FMT_W:   vec = rep_w;
            default: vec = '0;
        endcase
    end
endmodule

// File: rtl/lmv_extract.sv
// Module: lmv_extract
// Picks one lane of a vector and extends it to scalar width.
// Assumes the index was checked against the lane count beforehand.
module lmv_extract #(
    parameter int VEC_W = 128,
    parameter int SCL_W = 32,
    parameter int IDX_W = 4
) (
    input  logic [1:0]       fmt,
    input  logic             sign_ext,
    input  logic [IDX_W-1:0] idx,
    input  logic [VEC_W-1:0] vec,
    output logic [SCL_W-1:0] scalar
);
    import lmv_pkg::*;
    localparam int LANES_B = VEC_W / 8;
    localparam int LANES_H = VEC_W / 16;
    localparam int LANES_W = VEC_W / 32;
    localparam int BI = $clog2(LANES_B);
    localparam int HI = $clog2(LANES_H);
    localparam int WI = $clog2(LANES_W);

    logic [7:0]  lane_b [LANES_B];
    logic [15:0] lane_h [LANES_H];
    logic [31:0] lane_w [LANES_W];
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    genvar gi;
    generate
        for (gi = 0; gi < LANES_B; gi++) begin : g_b
            assign lane_b[gi] = vec[gi*8 +: 8];
        end
        for (gi = 0; gi < LANES_H; gi++) begin : g_h
            assign lane_h[gi] = vec[gi*16 +: 16];
        end
        for (gi = 0; gi < LANES_W; gi++) begin : g_w
            assign lane_w[gi] = vec[gi*32 +: 32];
        end
    endgenerate

    // Lane selection and sign or zero extension
    always_comb begin
        sel_b = lane_b[idx[BI-1:0]];
        sel_h = lane_h[idx[HI-1:0]];
        case (lmv_fmt_e'(fmt))
            FMT_B:   scalar = {{(SCL_W-8){sign_ext & sel_b[7]}}, sel_b};
            FMT_H:   scalar = {{(SCL_W-16){sign_ext & sel_h[15]}}, sel_h};
            FMT_W:   scalar = SCL_W'(lane_w[idx[WI-1:0]]);
            default: scalar = '0;
        endcase
    end
endmodule

// File: rtl/lane_move_unit.sv
// Module: lane_move_unit
// Top of the vector lane move unit: fill (scalar to all lanes) and
// indexed copy (one lane to scalar). The result is registered one cycle later.
// Assumes one request per cycle and no back-pressure; reset is synchronous, active low.
module lane_move_unit #(
    parameter int VEC_W = 128,
    parameter int SCL_W = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_fmt,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [SCL_W-1:0] req_scalar,
    input  logic [VEC_W-1:0] req_vec,
    output logic             res_valid,
    output logic             res_err,
    output logic [VEC_W-1:0] res_vec,
    output logic [SCL_W-1:0] res_scalar
);
    import lmv_pkg::*;

    logic             legal, is_fill;
    logic [VEC_W-1:0] fill_vec;
    logic [SCL_W-1:0] copy_val;

    lmv_decode #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_decode (
        .op(req_op), .fmt(req_fmt), .idx(req_idx),
        .legal(legal), .is_fill(is_fill)
    );

    lmv_fill #(.VEC_W(VEC_W), .SCL_W(SCL_W)) u_fill (
        .fmt(req_fmt), .scalar(req_scalar), .vec(fill_vec)
    );

    lmv_extract #(.VEC_W(VEC_W), .SCL_W(SCL_W), .IDX_W(IDX_W)) u_extract (
        .fmt(req_fmt), .sign_ext(lmv_op_e'(req_op) == OP_COPY_S),
        .idx(req_idx), .vec(req_vec), .scalar(copy_val)
    );

    // Result registers: capture on legal requests, pulse valid or error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_err    <= 1'b0;
            res_vec    <= '0;
            res_scalar <= '0;
        end else begin
            res_valid <= req_valid & legal;
            res_err   <= req_valid & ~legal;
            if (req_valid && legal) begin
                if (is_fill) begin
                    res_vec    <= fill_vec;
                    res_scalar <= '0;
                end else begin
                    res_vec    <= '0;
                    res_scalar <= copy_val;
                end
            end
        end
    end
endmodule

// File: rtl/lane_move_unit_chk.sv
// Module: lane_move_unit_chk
// Cycle-level properties of the lane move unit, bound to its top.
// Assumes the encodings listed in the brief.
module lane_move_unit_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic [1:0]   req_op,
    input logic [1:0]   req_fmt,
    input logic [3:0]   req_idx,
    input logic [31:0]  req_scalar,
    input logic         res_valid,
    input logic         res_err,
    input logic [127:0] res_vec,
    input logic [31:0]  res_scalar
);
    logic ok_req;

    // Independent legality view used as the antecedent
    always_comb begin
        ok_req = (req_op != 2'd3) && (req_fmt != 2'd3) &&
                 ((req_op == 2'd0) || (req_fmt == 2'd0) ||
                  (req_fmt == 2'd1 && req_idx < 4'd8) ||
                  (req_fmt == 2'd2 && req_idx < 4'd4));
    end

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_err));

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ok_req) |=> (res_valid && !res_err));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !res_err));

    assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ok_req) |=> (res_err && !res_valid));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ok_req) |=> ($stable(res_vec) && $stable(res_scalar)));

    assert_fill_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && req_fmt == 2'd0)
        |=> (res_vec == {16{$past(req_scalar[7:0])}} && res_scalar == 32'd0));

    assert_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2 && req_fmt == 2'd0)
        |=> (res_scalar[31:8] == 24'd0));

    assert_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1 && req_fmt == 2'd1 && req_idx < 4'd8)
        |=> (res_scalar[31:16] == {16{res_scalar[15]}} && res_vec == 128'd0));
endmodule

bind lane_move_unit lane_move_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_fmt(req_fmt), .req_idx(req_idx), .req_scalar(req_scalar),
    .res_valid(res_valid), .res_err(res_err), .res_vec(res_vec),
    .res_scalar(res_scalar)
);

// File: tb/lane_move_unit_bench.sv
// Directed bench for lane_move_unit: one task per scenario.
module lane_move_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [1:0]   req_op = '0;
    logic [1:0]   req_fmt = '0;
    logic [3:0]   req_idx = '0;
    logic [31:0]  req_scalar = '0;
    logic [127:0] req_vec = '0;
    logic         res_valid, res_err;
    logic [127:0] res_vec;
    logic [31:0]  res_scalar;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    localparam logic [127:0] VSRC = 128'h8F7E6D5C_4B3A2918_07F6E5D4_C3B2A190;

    always #4 clk = ~clk;

    lane_move_unit u_lane_move_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_fmt(req_fmt), .req_idx(req_idx), .req_scalar(req_scalar),
        .req_vec(req_vec), .res_valid(res_valid), .res_err(res_err),
        .res_vec(res_vec), .res_scalar(res_scalar)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_fill(input logic [1:0] fmt, input logic [31:0] s);
        logic [127:0] v = '0;
        for (int i = 0; i < 16; i++) if (fmt == 2'd0) v[i*8 +: 8] = s[7:0];
        for (int i = 0; i < 8; i++)  if (fmt == 2'd1) v[i*16 +: 16] = s[15:0];
        for (int i = 0; i < 4; i++)  if (fmt == 2'd2) v[i*32 +: 32] = s;
        return v;
    endfunction

    function automatic logic [31:0] exp_copy(input logic [1:0] op, input logic [1:0] fmt,
                                             input logic [3:0] idx, input logic [127:0] v);
        logic [127:0] sh;
        logic [31:0]  r;
        case (fmt)
            2'd0: begin sh = v >> (idx * 8);
                  r = (op == 2'd1) ? {{24{sh[7]}}, sh[7:0]} : {24'd0, sh[7:0]}; end
            2'd1: begin sh = v >> (idx * 16);
                  r = (op == 2'd1) ? {{16{sh[15]}}, sh[15:0]} : {16'd0, sh[15:0]}; end
            default: begin sh = v >> (idx * 32); r = sh[31:0]; end
        endcase
        return r;
    endfunction

    // Present one request for one cycle; results are visible at the following negedge
    task automatic send(input logic [1:0] op, input logic [1:0] fmt, input logic [3:0] idx,
                        input logic [31:0] s, input logic [127:0] v);
        req_valid = 1'b1; req_op = op; req_fmt = fmt; req_idx = idx;
        req_scalar = s; req_vec = v;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 valid", 128'(res_valid), 128'd0);
        chk("R1 err", 128'(res_err), 128'd0);
        chk("R1 vec", res_vec, 128'd0);
        chk("R1 scalar", 128'(res_scalar), 128'd0);
    endtask

    task automatic t_fill(input logic [1:0] fmt, input logic [3:0] idx, input logic [31:0] s);
        send(2'd0, fmt, idx, s, VSRC);
        chk("R9 fill valid", 128'(res_valid), 128'd1);
        chk("R3 fill vec", res_vec, exp_fill(fmt, s));
        chk("R3 fill scalar zero", 128'(res_scalar), 128'd0);
        @(negedge clk);
        chk("R9 single pulse", 128'(res_valid), 128'd0);
    endtask

    task automatic t_copy(input string tag, input logic [1:0] op, input logic [1:0] fmt,
                          input logic [3:0] idx);
        send(op, fmt, idx, 32'hDEAD_BEEF, VSRC);
        chk({tag, " valid"}, 128'(res_valid), 128'd1);
        chk({tag, " scalar"}, 128'(res_scalar), 128'(exp_copy(op, fmt, idx, VSRC)));
        chk({tag, " vec zero"}, res_vec, 128'd0);
    endtask

    task automatic t_reject(input string tag, input logic [1:0] op, input logic [1:0] fmt,
                            input logic [3:0] idx);
        logic [127:0] pv = res_vec;
        logic [31:0]  ps = res_scalar;
        send(op, fmt, idx, 32'h1234_5678, ~VSRC);
        chk({tag, " err"}, 128'(res_err), 128'd1);
        chk({tag, " no valid"}, 128'(res_valid), 128'd0);
        chk({tag, " vec hold"}, res_vec, pv);
        chk({tag, " scalar hold"}, 128'(res_scalar), 128'(ps));
        @(negedge clk);
        chk({tag, " err one cycle"}, 128'(res_err), 128'd0);
    endtask

    task automatic t_back_to_back();
        req_valid = 1'b1; req_op = 2'd2; req_fmt = 2'd0; req_idx = 4'd1; req_vec = VSRC;
        @(negedge clk);
        chk("R9 b2b first", 128'(res_scalar), 128'h0000_00A1);
        req_idx = 4'd14;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 b2b second valid", 128'(res_valid), 128'd1);
        chk("R9 b2b second", 128'(res_scalar), 128'h0000_007E);
        @(negedge clk);
        chk("R9 idle after b2b", 128'(res_valid), 128'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_fill(2'd0, 4'd0, 32'hCAFE_F00D);           // R3 byte
        t_fill(2'd1, 4'd9, 32'h0102_8A3C);           // R3 half, R7 index ignored
        t_fill(2'd2, 4'd15, 32'h89AB_CDEF);          // R3 word, R7 index ignored
        t_copy("R4 byte lane0", 2'd1, 2'd0, 4'd0);   // 0x90 -> negative
        t_copy("R4 byte lane3", 2'd1, 2'd0, 4'd3);   // 0xC3
        t_copy("R4 half lane7", 2'd1, 2'd1, 4'd7);
        t_copy("R5 byte lane15", 2'd2, 2'd0, 4'd15);
        t_copy("R5 half lane0", 2'd2, 2'd1, 4'd0);
        t_copy("R6 word signed lane3", 2'd1, 2'd2, 4'd3);
        t_copy("R6 word unsigned lane1", 2'd2, 2'd2, 4'd1);
        t_copy("R2 lane order half lane4", 2'd2, 2'd1, 4'd4);
        t_reject("R7 half idx8", 2'd1, 2'd1, 4'd8);
        t_reject("R7 word idx4", 2'd2, 2'd2, 4'd4);
        t_reject("R8 dword fmt", 2'd0, 2'd3, 4'd0);
        t_reject("R8 rsvd op", 2'd3, 2'd0, 4'd0);
        t_back_to_back();
        send(2'd0, 2'd0, 4'd0, 32'hFF, VSRC);
        req_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        t_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule